// File: doc/BRIEF.md
# Timer capture/compare/PWM channel

This block is a single channel of a general-purpose timer. It does not own a counter. The timer core supplies several signals that all of its channels share: the current count, the period top value, the counting direction, a one-cycle pulse when the count is at zero (the period boundary), and a timer-wide center-aligned select. From these signals the channel works in one of four ways. It can latch the count when an edge arrives on its pin (capture). It can act on its pin when the count equals its value register (compare). It can drive an edge-aligned PWM waveform or a center-aligned PWM waveform.

Software reaches the channel through a two-word register bus. Word 0 is control and status. Word 1 is the channel value. An event flag raises an interrupt request when the interrupt enable is set. Clearing the flag takes two steps: software reads the control word while the flag is 1, then writes a 0 to the flag bit. If a new event lands between those two steps, the clear is cancelled, so an event can never be dropped while an earlier one is being acknowledged. In both PWM modes, a new value written to the value register only takes effect at the next period boundary. The flag stays low when the programmed duty is 0% or 100%.

Top module: `tmr_ch`

## Requirements
- R1: Control word layout: bit 7 is the event flag, bit 6 the interrupt enable, bit 5 the PWM select, bit 4 the compare select, and bits 3:2 the edge/level field. Mode decode follows this priority: the center-aligned input high selects center PWM; otherwise the PWM select high selects edge PWM; otherwise the compare select picks compare (1) or capture (0). The enable and select fields read back as written.
- R2: In capture mode, the pin passes through a two-flop synchronizer. The edge/level field picks the active edge: 01 rising, 10 falling, 11 both. An active edge sets the flag and loads the current count into the value register. Both results are visible three clock edges after the pin changes.
- R3: In compare mode, a match between the count and the value register sets the flag and acts on the pin according to the edge/level field: 01 toggles it, 10 drives it low, 11 drives it high.
- R4: The interrupt output is high exactly while the flag and the interrupt enable are both 1.
- R5: The flag clears only when a write of 0 to bit 7 of the control word follows a read of the control word that was made while the flag was 1. A 0 written without such a read, and any 1 written to bit 7, leave the flag unchanged.
- R6: An event that arrives after the arming read and before the clearing write cancels the clear, so the flag stays 1.
- R7: After reset the control word reads 0, and the output enable and the interrupt output are low.
- R8: The output enable is low when the edge/level field is 00 and also in capture mode. It is high in the other modes.
- R9: In edge PWM, after the clock edge that samples count c, the active level is present iff c < V, where V is the value in use. Field 10 gives a high-true pin and field x1 gives a low-true pin.
- R10: In center PWM, where the count rises from 0 to top−1 and then falls from top to 1 with the direction input high, the active level after count c is present iff c < V while counting up and iff c ≤ V while counting down. Polarity follows R9.
- R11: In both PWM modes, a value written mid-period takes effect at the next period boundary.
- R12: In PWM modes a match sets the flag, except when V is 0 or V gives 100% duty (V > top for edge PWM, V ≥ top for center PWM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Word select: 0 control/status, 1 value |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected word |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_top | input | CNT_W | Counter period top value |
| cnt_down | input | 1 | Counter is counting down |
| cnt_wrap | input | 1 | Count is at the period boundary this cycle |
| cnt_center | input | 1 | Timer-wide center-aligned PWM select |
| pin_in | input | 1 | Channel pin input |
| pin_out | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel pin output enable |
| irq | output | 1 | Channel interrupt request |

## Verification
The hardest case to reach is the cancelled clear. A capture edge has to land after the arming read and before the zeroing write. The synchronizer delays that edge by a fixed number of cycles, which makes the timing precise. The stimulus toggles the pin right after the read, waits out the synchronizer latency, and only then issues the write. The result is observed through the interrupt output, so the check itself does not re-arm the flag. The mid-period value update is also hard to reach. The bench stops at a chosen count inside the period, writes a value that would change the pin at once, and compares every following cycle against the old value until the boundary.

// File: rtl/tmr_ch_pkg.sv
package tmr_ch_pkg;

   typedef enum logic [1:0] {
      CH_CAPTURE = 2'd0,
      CH_COMPARE = 2'd1,
      CH_EPWM    = 2'd2,
      CH_CPWM    = 2'd3
   } ch_mode_e;

   localparam int CTL_FLAG_BIT = 7;
   localparam int CTL_IE_BIT   = 6;
   localparam int CTL_PWM_BIT  = 5;
   localparam int CTL_CMP_BIT  = 4;
   localparam int CTL_LVL_HI   = 3;
   localparam int CTL_LVL_LO   = 2;

   typedef struct packed {
      logic       ie;
      logic       pwm_sel;
      logic       cmp_sel;
      logic [1:0] lvl;
   } ch_ctrl_t;

   function automatic ch_mode_e decode_mode(logic center, logic pwm_sel, logic cmp_sel);
      if (center)       return CH_CPWM;
      else if (pwm_sel) return CH_EPWM;
      else if (cmp_sel) return CH_COMPARE;
      else              return CH_CAPTURE;
   endfunction

endpackage

// File: rtl/tmr_ch_edge_det.sv
module tmr_ch_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_ch_edge_det: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], pin_i};
   end

   assign rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
   assign fall_o = ~chain_q[LAST-1] &  chain_q[LAST];

endmodule

// File: rtl/tmr_ch_flag.sv
module tmr_ch_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wr_flag_i,
   output logic flag_o
);
   logic flag_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (evt_i) begin
         armed_q <= 1'b0;
      end else if (wr_i) begin
         armed_q <= 1'b0;
      end else if (rd_i && flag_q) begin
         armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (evt_i) begin
         flag_q <= 1'b1;
      end else if (wr_i && !wr_flag_i && armed_q) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q);

   assert_idle_flag_stays_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !evt_i) |=> !flag_q);

   assert_clear_needs_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(armed_q && wr_i && !wr_flag_i));

   assert_event_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> !armed_q);

endmodule

// File: rtl/tmr_ch_wave.sv
module tmr_ch_wave
   import tmr_ch_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ch_mode_e         mode_i,
   input  logic [1:0]       lvl_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] top_i,
   input  logic             down_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             match_evt_o,
   output logic             pin_o,
   output logic             oe_o
);
   logic out_q;
   logic out_d;
   logic match;
   logic is_pwm;
   logic duty_zero;
   logic duty_full;

   assign match     = (cnt_i == val_i);
   assign is_pwm    = (mode_i == CH_EPWM) || (mode_i == CH_CPWM);
   assign duty_zero = (val_i == '0);
   assign duty_full = (mode_i == CH_CPWM) ? (val_i >= top_i) : (val_i > top_i);

   assign match_evt_o = match && ((mode_i == CH_COMPARE) ||
                                  (is_pwm && !duty_zero && !duty_full));

   always_comb begin
      out_d = out_q;
      case (mode_i)
         CH_COMPARE: begin
            if (match) begin
               case (lvl_i)
                  2'b01:   out_d = ~out_q;
                  2'b10:   out_d = 1'b0;
                  2'b11:   out_d = 1'b1;
                  default: out_d = out_q;
               endcase
            end
         end
         CH_EPWM: begin
            if (match)       out_d = 1'b0;
            else if (wrap_i) out_d = !duty_zero;
         end
         CH_CPWM: begin
            if (match)       out_d = down_i;
            else if (wrap_i) out_d = !duty_zero;
         end
         default: out_d = out_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end

   assign pin_o = is_pwm ? (out_q ^ lvl_i[0]) : out_q;
   assign oe_o  = (lvl_i != 2'b00) && (mode_i != CH_CAPTURE);

   assert_epwm_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == CH_EPWM && wrap_i && val_i == '0) |=> !out_q);

   assert_cpwm_up_match_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == CH_CPWM && match && !down_i) |=> !out_q);

endmodule

// File: rtl/tmr_ch.sv
module tmr_ch
   import tmr_ch_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit PWM_BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cnt_top,
   input  logic             cnt_down,
   input  logic             cnt_wrap,
   input  logic             cnt_center,
   input  logic             pin_in,
   output logic             pin_out,
   output logic             pin_oe,
   output logic             irq
);
   localparam int CTL_W = CTL_FLAG_BIT + 1;

   if (CNT_W < CTL_W) begin : g_bad_width
      $error("tmr_ch: CNT_W must hold the control word");
   end

   ch_ctrl_t         ctrl_q;
   ch_mode_e         mode;
   logic             flag;
   logic             rise;
   logic             fall;
   logic             cap_evt;
   logic             cmp_evt;
   logic             is_pwm;
   logic [CNT_W-1:0] val_buf;
   logic [CNT_W-1:0] eff_val;
   logic             ctl_rd;
   logic             ctl_wr;
   logic             val_wr;
   logic [CTL_W-1:0] ctl_word;

   assign ctl_rd = bus_rd && !bus_addr;
   assign ctl_wr = bus_wr && !bus_addr;
   assign val_wr = bus_wr &&  bus_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctl_wr) begin
         ctrl_q <= bus_wdata[CTL_IE_BIT:CTL_LVL_LO];
      end
   end

   assign mode   = decode_mode(cnt_center, ctrl_q.pwm_sel, ctrl_q.cmp_sel);
   assign is_pwm = (mode == CH_EPWM) || (mode == CH_CPWM);

   tmr_ch_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign cap_evt = (mode == CH_CAPTURE) &&
                    ((ctrl_q.lvl[0] && rise) || (ctrl_q.lvl[1] && fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_buf <= '0;
      else if (cap_evt) val_buf <= cnt_val;
      else if (val_wr)  val_buf <= bus_wdata;
   end

   if (PWM_BUFFERED) begin : g_staged
      logic [CNT_W-1:0] val_act;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  val_act <= '0;
         else if (!is_pwm || cnt_wrap) val_act <= val_buf;
      end
      assign eff_val = (is_pwm && !cnt_wrap) ? val_act : val_buf;

      assert_value_held_in_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (is_pwm && !cnt_wrap) |=> $stable(val_act));
   end else begin : g_direct
      assign eff_val = val_buf;
   end

   tmr_ch_wave #(.CNT_W(CNT_W)) wave_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .lvl_i       (ctrl_q.lvl),
      .cnt_i       (cnt_val),
      .top_i       (cnt_top),
      .down_i      (cnt_down),
      .wrap_i      (cnt_wrap),
      .val_i       (eff_val),
      .match_evt_o (cmp_evt),
      .pin_o       (pin_out),
      .oe_o        (pin_oe)
   );

   tmr_ch_flag flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (cap_evt | cmp_evt),
      .rd_i      (ctl_rd),
      .wr_i      (ctl_wr),
      .wr_flag_i (bus_wdata[CTL_FLAG_BIT]),
      .flag_o    (flag)
   );

   assign ctl_word  = {flag, ctrl_q, 2'b00};
   assign bus_rdata = bus_addr ? val_buf : CNT_W'(ctl_word);
   assign irq       = flag & ctrl_q.ie;

   assert_capture_latches_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (val_buf == $past(cnt_val)));

   assert_irq_follows_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[CTL_IE_BIT] && flag && !cap_evt && !cmp_evt &&
       bus_wdata[CTL_FLAG_BIT]) |=> irq);

endmodule

// File: tb/tmr_ch_tb_top.sv
module tmr_ch_tb_top;
   localparam int TOP = 7;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_rd, bus_wr, bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [15:0] cnt_val, cnt_top, last_cnt;
   logic        cnt_down, cnt_wrap, cnt_center;
   logic        pin_in, pin_out, pin_oe, irq;

   int vecs = 0;
   int fails = 0;
   bit run = 0;
   bit chk_on = 0;
   bit pol = 0;
   int model_v = 0;
   int pend_v = 0;
   string pwm_tag = "R9";

   always #10 clk = ~clk;

   tmr_ch dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_val(cnt_val), .cnt_top(cnt_top), .cnt_down(cnt_down),
      .cnt_wrap(cnt_wrap), .cnt_center(cnt_center), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(string tag, int act, int exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   endtask

   task automatic adv();
      if (cnt_center) begin
         if (!cnt_down) begin
            if (int'(cnt_val) == TOP - 1) begin cnt_val = 16'(TOP); cnt_down = 1'b1; end
            else cnt_val = cnt_val + 16'd1;
         end else begin
            if (cnt_val == 16'd1) begin cnt_val = 16'd0; cnt_down = 1'b0; end
            else cnt_val = cnt_val - 16'd1;
         end
      end else begin
         cnt_down = 1'b0;
         cnt_val  = (int'(cnt_val) == TOP) ? 16'd0 : cnt_val + 16'd1;
      end
      cnt_wrap = (cnt_val == 16'd0);
   endtask

   task automatic cyc();
      bit act;
      @(posedge clk);
      @(negedge clk);
      last_cnt = cnt_val;
      if (cnt_wrap) model_v = pend_v;
      if (chk_on) begin
         act = cnt_down ? (int'(cnt_val) <= model_v) : (int'(cnt_val) < model_v);
         check(cnt_center ? "R10 center pwm" : pwm_tag, int'(pin_out), int'(act ^ pol));
      end
      if (run) adv();
   endtask

   task automatic wr(bit a, logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      cyc();
      bus_wr = 1'b0;
      if (a) pend_v = int'(d);
   endtask

   task automatic rd(bit a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      cyc();
      bus_rd = 1'b0;
   endtask

   task automatic clear_flag();
      logic [15:0] d;
      rd(1'b0, d);
      wr(1'b0, d & 16'h007F);
   endtask

   task automatic wait_wrap();
      while (!cnt_wrap) cyc();
   endtask

   task automatic toggle_evt();
      pin_in = ~pin_in;
      repeat (4) cyc();
   endtask

   function automatic logic [15:0] ctl(bit ie, bit ps, bit cs, logic [1:0] lvl);
      return {8'h00, 1'b0, ie, ps, cs, lvl, 2'b00};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
   end

   initial begin
      logic [15:0] d;
      int exp_val;
      bit exp_flag;
      bit m;
      rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
      cnt_val = '0; cnt_top = 16'(TOP); cnt_down = 0; cnt_wrap = 1; cnt_center = 0;
      pin_in = 0; last_cnt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      rd(1'b0, d);
      check("R7 ctrl after reset", int'(d), 0);
      check("R7 oe after reset", int'(pin_oe), 0);
      check("R7 irq after reset", int'(irq), 0);

      // R2 capture edge sweep, R8 oe low in capture
      exp_val = 0;
      for (int e = 1; e < 4; e++) begin
         wr(1'b0, ctl(0, 0, 0, 2'(e)));
         check("R8 oe in capture", int'(pin_oe), 0);
         for (int k = 0; k < 2; k++) begin
            clear_flag();
            cnt_val = 16'(16'h100 + e * 4 + k);
            pin_in = ~pin_in;
            repeat (2) cyc();
            rd(1'b0, d);
            check("R2 no flag before sync latency", int'(d[7]), 0);
            cyc();
            exp_flag = pin_in ? e[0] : e[1];
            if (exp_flag) exp_val = int'(cnt_val);
            rd(1'b0, d);
            check("R2 capture flag", int'(d[7]), int'(exp_flag));
            rd(1'b1, d);
            check("R2 captured value", int'(d), exp_val);
         end
      end

      // R4 R5 R6 handshake, capture on both edges
      wr(1'b0, ctl(0, 0, 0, 2'b11));
      clear_flag();
      toggle_evt();
      wr(1'b0, ctl(1, 0, 0, 2'b11));
      check("R5 zero write without read keeps flag", int'(irq), 1);
      rd(1'b0, d);
      check("R1 readback fields", int'(d[6:2]), 5'b10011);
      toggle_evt();
      wr(1'b0, ctl(1, 0, 0, 2'b11));
      check("R6 event after read cancels clear", int'(irq), 1);
      rd(1'b0, d);
      wr(1'b0, ctl(1, 0, 0, 2'b11));
      check("R5 read then zero write clears", int'(irq), 0);
      wr(1'b0, ctl(1, 0, 0, 2'b11) | 16'h0080);
      check("R5 write one has no effect", int'(irq), 0);
      wr(1'b0, ctl(0, 0, 0, 2'b11));
      toggle_evt();
      check("R4 irq masked by enable", int'(irq), 0);
      rd(1'b0, d);
      check("R4 flag set while masked", int'(d[7]), 1);
      wr(1'b0, ctl(1, 0, 0, 2'b11) | 16'h0080);
      check("R4 irq with enable and flag", int'(irq), 1);

      // R3 compare sweep, R8 oe
      cnt_val = 0; cnt_wrap = 1; cnt_down = 0;
      wr(1'b1, 16'd5);
      for (int e = 1; e < 4; e++) begin
         wr(1'b0, ctl(0, 0, 1, 2'(e)));
         clear_flag();
         check("R8 oe in compare", int'(pin_oe), 1);
         m = pin_out;
         run = 1;
         for (int i = 0; i < 2 * (TOP + 1); i++) begin
            cyc();
            if (last_cnt == 16'd5) m = (e == 1) ? ~m : (e == 3);
            check("R3 compare pin", int'(pin_out), int'(m));
         end
         run = 0; cnt_val = 0; cnt_wrap = 1;
         rd(1'b0, d);
         check("R3 compare flag", int'(d[7]), 1);
      end
      wr(1'b0, ctl(0, 0, 1, 2'b00));
      check("R8 oe released by level 00", int'(pin_oe), 0);

      // R9 R10 R12 PWM sweep
      run = 1;
      for (int c = 0; c < 2; c++) begin
         for (int p = 0; p < 2; p++) begin
            chk_on = 0;
            cnt_center = c[0]; cnt_val = 0; cnt_down = 0; cnt_wrap = 1;
            pol = p[0];
            wr(1'b0, ctl(0, !c[0], 0, p[0] ? 2'b01 : 2'b10));
            model_v = pend_v;
            check("R1 oe in pwm", int'(pin_oe), 1);
            wait_wrap();
            chk_on = 1;
            for (int v = 0; v <= TOP + 1; v++) begin
               wr(1'b1, 16'(v));
               wait_wrap();
               clear_flag();
               wait_wrap();
               repeat (c ? 2 * TOP : TOP + 1) cyc();
               rd(1'b0, d);
               exp_flag = !(v == 0 || (c ? v >= TOP : v > TOP));
               check("R12 pwm flag", int'(d[7]), int'(exp_flag));
            end
         end
      end

      // R11 mid-period write, edge PWM high-true
      chk_on = 0; cnt_center = 0; cnt_val = 0; cnt_down = 0; cnt_wrap = 1; pol = 0;
      wr(1'b0, ctl(0, 1, 0, 2'b10));
      wr(1'b1, 16'd2);
      model_v = pend_v;
      wait_wrap();
      chk_on = 1;
      pwm_tag = "R11 staged value";
      cyc();
      wait_wrap();
      cyc();
      while (cnt_val != 16'd4) cyc();
      wr(1'b1, 16'd6);
      repeat (2 * (TOP + 1)) cyc();
      chk_on = 0;
      summary();
   end
endmodule